// File: doc/BRIEF.md
# Single-Pin Dimming Mode Selector

This block watches one logic-level control line and turns its activity into three decisions: whether the LED driver is running, which of two dimming schemes it uses, and whether that choice is already fixed. The two schemes are duty-cycle dimming, where the line carries a PWM signal whose duty sets the brightness, and serial dimming, where a one-wire command stream on the same line programs the brightness. The serial decoder, the reference filter and the power stage are separate blocks that read the flags this block produces.

The device wakes from shutdown on a rising edge of the line. That edge opens a detection window. For a short hold-off at the start of the window the line is not examined. After the hold-off, one low pulse that lasts longer than the detection time selects serial mode at once. If the window closes without such a pulse, duty-cycle mode is selected. The choice is then kept until the line stays low long enough to shut the device down. All durations are counted in ticks of an external time base, normally one tick per microsecond, and every limit is a parameter.

Top module: `dim_mode_sel`

## Requirements
- R1: While reset is applied and directly after it, `enable`, `mode_serial` and `mode_locked` are all 0.
- R2: In shutdown, a low-to-high transition of the synchronized line sets `enable` to 1 and opens the detection window. While the window is open, `mode_locked` stays 0.
- R3: Inside the window, a single unbroken low that counts more than `DET_TICKS` ticks selects serial mode (`mode_serial`=1, `mode_locked`=1). A low that counts exactly `DET_TICKS` ticks does not select it.
- R4: Ticks that fall before `DELAY_TICKS` ticks of the window have elapsed are not counted toward the serial-selection low.
- R5: When `WIN_TICKS` ticks have elapsed with no qualifying low, duty-cycle mode is selected (`mode_serial`=0, `mode_locked`=1). If the qualifying low completes on the last tick of the window, serial mode wins.
- R6: After the mode is locked, no line activity other than shutdown changes `mode_serial`.
- R7: When the line is low for more than `SHDN_TICKS` consecutive counted ticks, the block enters shutdown, which sets `enable`, `mode_serial` and `mode_locked` to 0. A low of exactly `SHDN_TICKS` ticks keeps the device enabled.
- R8: In serial mode, ticks during which `ack_hold`=1 are not counted toward shutdown. In duty-cycle mode, `ack_hold` has no effect.
- R9: All timing counters advance only on cycles where `tick` is 1.
- R10: A rising edge after a shutdown starts a new detection window, so the mode is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one cycle wide per counted tick |
| pin_raw | input | 1 | Asynchronous control line sample |
| ack_hold | input | 1 | High while the serial decoder holds the line low for acknowledge |
| enable | output | 1 | Device running |
| mode_serial | output | 1 | 1 = serial dimming, 0 = duty-cycle dimming |
| mode_locked | output | 1 | Mode decision made for this start |

## Verification
Two decisions can land on the same tick: the window expiring and the serial-selection low reaching its threshold. The bench provokes this by placing the start of the low exactly `WIN_TICKS-1-DET_TICKS` ticks into the window, so that the threshold tick is also the last tick of the window. It expects serial mode in that case, and duty-cycle mode when the low starts one tick later. The same-tick pairing of shutdown counting and `ack_hold` is covered by holding the line low past the shutdown limit with `ack_hold` high, once in each mode.

// File: rtl/dms_pkg.sv
package dms_pkg;

   typedef enum logic [1:0] {
      ST_OFF = 2'd0,
      ST_WIN = 2'd1,
      ST_PWM = 2'd2,
      ST_SER = 2'd3
   } dms_state_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/dms_pin_sync.sv
module dms_pin_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_s,
   output logic rise
);

   logic [STAGES-1:0] chain;
   logic              pin_d;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= pin_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], pin_in};
         end
      end
   endgenerate

   assign pin_s = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= pin_s;
   end

   assign rise = pin_s & ~pin_d;

endmodule

// File: rtl/dms_tick_cnt.sv
module dms_tick_cnt #(
   parameter int unsigned MAX_COUNT = 1000,
   parameter int unsigned CW        = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] count
);

   localparam logic [CW-1:0] TOP = CW'(MAX_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (clr)                 count <= '0;
      else if (inc && count != TOP) count <= count + 1'b1;
   end

endmodule

// File: rtl/dms_mode_fsm.sv
module dms_mode_fsm
   import dms_pkg::*;
#(
   parameter int unsigned DELAY_TICKS = 100,
   parameter int unsigned DET_TICKS   = 260,
   parameter int unsigned WIN_TICKS   = 1000,
   parameter int unsigned SHDN_TICKS  = 2500,
   parameter int unsigned WIN_W       = 10,
   parameter int unsigned LOW_W       = 9,
   parameter int unsigned SD_W        = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             pin_s,
   input  logic             rise,
   input  logic             ack_hold,
   input  logic [WIN_W-1:0] win_cnt,
   input  logic [LOW_W-1:0] low_cnt,
   input  logic [SD_W-1:0]  sd_cnt,
   output logic             win_clr,
   output logic             win_inc,
   output logic             low_clr,
   output logic             low_inc,
   output logic             sd_clr,
   output logic             sd_inc,
   output dms_state_t       state
);

   localparam logic [WIN_W-1:0] DELAY_V = WIN_W'(DELAY_TICKS);
   localparam logic [WIN_W-1:0] WLAST_V = WIN_W'(WIN_TICKS - 1);
   localparam logic [LOW_W-1:0] DET_V   = LOW_W'(DET_TICKS);
   localparam logic [SD_W-1:0]  SHDN_V  = SD_W'(SHDN_TICKS);

   dms_state_t state_nx;
   logic       in_win;
   logic       delay_done;
   logic       det_hit;
   logic       win_end;
   logic       sd_hit;
   logic       ack_mask;

   assign in_win     = (state == ST_WIN);
   assign delay_done = (win_cnt >= DELAY_V);
   assign ack_mask   = (state == ST_SER) && ack_hold;

   // Window timer runs only inside the detection window.
   assign win_clr = !in_win;
   assign win_inc = tick && in_win;
   assign win_end = win_inc && (win_cnt == WLAST_V);

   // The selection low only counts once the hold-off has elapsed.
   assign low_clr = pin_s || !in_win;
   assign low_inc = tick && !pin_s && delay_done;
   assign det_hit = low_inc && in_win && (low_cnt == DET_V);

   // The shutdown low counts in every powered state, except during an acknowledge pull-down.
   assign sd_clr = pin_s || (state == ST_OFF);
   assign sd_inc = tick && !pin_s && !ack_mask;
   assign sd_hit = sd_inc && (state != ST_OFF) && (sd_cnt == SHDN_V);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_OFF: if (rise) state_nx = ST_WIN;
         ST_WIN: begin
            if (sd_hit)       state_nx = ST_OFF;
            else if (det_hit) state_nx = ST_SER;
            else if (win_end) state_nx = ST_PWM;
         end
         ST_PWM: if (sd_hit) state_nx = ST_OFF;
         ST_SER: if (sd_hit) state_nx = ST_OFF;
         default: state_nx = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_OFF;
      else        state <= state_nx;
   end

endmodule

// File: rtl/dim_mode_sel.sv
module dim_mode_sel
   import dms_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DELAY_TICKS = 100,
   parameter int unsigned DET_TICKS   = 260,
   parameter int unsigned WIN_TICKS   = 1000,
   parameter int unsigned SHDN_TICKS  = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pin_raw,
   input  logic ack_hold,
   output logic enable,
   output logic mode_serial,
   output logic mode_locked
);

   localparam int unsigned WIN_W = cnt_width(WIN_TICKS);
   localparam int unsigned LOW_W = cnt_width(DET_TICKS);
   localparam int unsigned SD_W  = cnt_width(SHDN_TICKS);

   generate
      if (SYNC_STAGES < 1)
         $error("dim_mode_sel: SYNC_STAGES must be at least 1");
      if (WIN_TICKS < 2)
         $error("dim_mode_sel: WIN_TICKS must be at least 2");
      if (DELAY_TICKS >= WIN_TICKS)
         $error("dim_mode_sel: hold-off must end inside the window");
      if (DELAY_TICKS + DET_TICKS >= WIN_TICKS)
         $error("dim_mode_sel: a selection low must fit inside the window");
      if (SHDN_TICKS <= DET_TICKS)
         $error("dim_mode_sel: shutdown low must exceed the selection low");
   endgenerate

   logic             pin_s;
   logic             rise;
   logic             win_clr, win_inc;
   logic             low_clr, low_inc;
   logic             sd_clr, sd_inc;
   logic [WIN_W-1:0] win_cnt;
   logic [LOW_W-1:0] low_cnt;
   logic [SD_W-1:0]  sd_cnt;
   dms_state_t       state;

   dms_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_in (pin_raw),
      .pin_s  (pin_s),
      .rise   (rise)
   );

   dms_tick_cnt #(.MAX_COUNT(WIN_TICKS), .CW(WIN_W)) u_win_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (win_clr),
      .inc   (win_inc),
      .count (win_cnt)
   );

   dms_tick_cnt #(.MAX_COUNT(DET_TICKS), .CW(LOW_W)) u_low_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (low_clr),
      .inc   (low_inc),
      .count (low_cnt)
   );

   dms_tick_cnt #(.MAX_COUNT(SHDN_TICKS), .CW(SD_W)) u_sd_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (sd_clr),
      .inc   (sd_inc),
      .count (sd_cnt)
   );

   dms_mode_fsm #(
      .DELAY_TICKS (DELAY_TICKS),
      .DET_TICKS   (DET_TICKS),
      .WIN_TICKS   (WIN_TICKS),
      .SHDN_TICKS  (SHDN_TICKS),
      .WIN_W       (WIN_W),
      .LOW_W       (LOW_W),
      .SD_W        (SD_W)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .pin_s    (pin_s),
      .rise     (rise),
      .ack_hold (ack_hold),
      .win_cnt  (win_cnt),
      .low_cnt  (low_cnt),
      .sd_cnt   (sd_cnt),
      .win_clr  (win_clr),
      .win_inc  (win_inc),
      .low_clr  (low_clr),
      .low_inc  (low_inc),
      .sd_clr   (sd_clr),
      .sd_inc   (sd_inc),
      .state    (state)
   );

   assign enable      = (state != ST_OFF);
   assign mode_serial = (state == ST_SER);
   assign mode_locked = (state == ST_SER) || (state == ST_PWM);

endmodule

// File: rtl/dim_mode_sel_chk.sv
module dim_mode_sel_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic pin_s,
   input logic ack_hold,
   input logic enable,
   input logic mode_serial,
   input logic mode_locked
);

   // R2: a locked mode exists only while powered
   a_r2_lock_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      mode_locked |-> enable);

   // R7: shutdown leaves no mode behind
   a_r7_off_clears_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (!mode_serial && !mode_locked));

   // R7: shutdown only follows a counted low tick
   a_r7_off_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enable) |-> ($past(!pin_s) && $past(tick)));

   // R6: locked mode holds until power goes away
   a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      mode_locked |=> (!enable || $stable(mode_serial)));

   // R3: serial selection happens on a low tick
   a_r3_serial_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_serial) |-> ($past(!pin_s) && $past(tick)));

   // R8: acknowledge pull-down never shuts a serial device down
   a_r8_ack_protects: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_serial && ack_hold) |=> enable);

   // R9: without a tick no timed decision changes
   a_r9_no_tick_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !mode_locked && !tick) |=> !mode_locked);

endmodule

bind dim_mode_sel dim_mode_sel_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .pin_s       (pin_s),
   .ack_hold    (ack_hold),
   .enable      (enable),
   .mode_serial (mode_serial),
   .mode_locked (mode_locked)
);

// File: tb/tb_dim_mode_sel.sv
`timescale 1ns/1ps
module tb_dim_mode_sel;

   localparam int unsigned P_DELAY = 10;
   localparam int unsigned P_DET   = 26;
   localparam int unsigned P_WIN   = 100;
   localparam int unsigned P_SHDN  = 250;

   // Vector table: offset of the low in ticks from the window start,
   // its length in ticks (0 = no low), and the expected serial flag.
   localparam int NV = 10;
   localparam int V_OFS [NV] = '{20, 20, 20,  9, 10,  2, 73, 74, 95,  0};
   localparam int V_LEN [NV] = '{40, 26, 27, 27, 27, 30, 60, 60, 10,  0};
   localparam bit V_SER [NV] = '{ 1,  0,  1,  0,  1,  0,  1,  0,  0,  0};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic pin_raw = 1'b0;
   logic ack_hold = 1'b0;
   logic enable, mode_serial, mode_locked;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 1'b0;

   bit arm = 1'b0;
   bit saw_off = 1'b0;
   bit off_ser = 1'b0;
   bit off_lock = 1'b0;

   always #5 clk = ~clk;

   dim_mode_sel #(
      .SYNC_STAGES (2),
      .DELAY_TICKS (P_DELAY),
      .DET_TICKS   (P_DET),
      .WIN_TICKS   (P_WIN),
      .SHDN_TICKS  (P_SHDN)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .pin_raw     (pin_raw),
      .ack_hold    (ack_hold),
      .enable      (enable),
      .mode_serial (mode_serial),
      .mode_locked (mode_locked)
   );

   always @(negedge clk) begin
      if (arm && !enable && !saw_off) begin
         saw_off  = 1'b1;
         off_ser  = mode_serial;
         off_lock = mode_locked;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic arm_mon();
      saw_off = 1'b0;
      arm     = 1'b1;
   endtask

   task automatic go_off();
      pin_raw = 1'b0;
      step(P_SHDN + 50);
      chk(!enable && !mode_locked && !mode_serial, "R7 off state",
          {enable, mode_locked, mode_serial}, 0);
   endtask

   task automatic run_vec(input int ofs, input int len, input bit exp_ser);
      go_off();
      pin_raw = 1'b1;
      step(ofs + 1);
      if (len > 0) begin
         pin_raw = 1'b0;
         step(len);
         pin_raw = 1'b1;
      end
      step(150);
      chk(enable && mode_locked, "R3/R4/R5/R10 locked", {enable, mode_locked}, 3);
      chk(mode_serial == exp_ser, "R3/R4/R5 mode", mode_serial, exp_ser);
   endtask

   initial begin
      step(4);
      // R1
      chk(!enable && !mode_serial && !mode_locked, "R1 reset",
          {enable, mode_serial, mode_locked}, 0);
      rst_n = 1'b1;
      step(3);
      chk(!enable && !mode_serial && !mode_locked, "R1 after reset",
          {enable, mode_serial, mode_locked}, 0);

      for (int i = 0; i < NV; i++) run_vec(V_OFS[i], V_LEN[i], V_SER[i]);

      // R2: enabled and undecided inside the window
      go_off();
      pin_raw = 1'b1;
      step(20);
      chk(enable && !mode_locked, "R2 window open", {enable, mode_locked}, 2);

      // R9: with no tick the window never closes and a long low does nothing
      tick = 1'b0;
      step(300);
      chk(enable && !mode_locked, "R9 window frozen", {enable, mode_locked}, 2);
      pin_raw = 1'b0;
      step(400);
      pin_raw = 1'b1;
      step(5);
      chk(enable && !mode_locked, "R9 low ignored", {enable, mode_locked}, 2);
      tick = 1'b1;
      step(150);
      chk(mode_locked && !mode_serial, "R9 window resumes", {mode_locked, mode_serial}, 2);

      // R6: duty-cycle mode ignores a long selection-like low
      pin_raw = 1'b0;
      step(40);
      pin_raw = 1'b1;
      step(5);
      chk(mode_locked && !mode_serial, "R6 pwm held", {mode_locked, mode_serial}, 2);

      // R8: acknowledge has no effect in duty-cycle mode
      ack_hold = 1'b1;
      arm_mon();
      pin_raw = 1'b0;
      step(P_SHDN + 10);
      pin_raw = 1'b1;
      step(5);
      arm = 1'b0;
      chk(saw_off, "R8 pwm ack ignored", saw_off, 1);
      ack_hold = 1'b0;

      // Serial mode
      go_off();
      pin_raw = 1'b1;
      step(21);
      pin_raw = 1'b0;
      step(40);
      pin_raw = 1'b1;
      step(150);
      chk(mode_serial && mode_locked, "R3 serial", {mode_serial, mode_locked}, 3);

      // R6: serial mode ignores a later short low
      pin_raw = 1'b0;
      step(40);
      pin_raw = 1'b1;
      step(5);
      chk(mode_serial, "R6 serial held", mode_serial, 1);

      // R8: acknowledge pull-down does not count toward shutdown
      ack_hold = 1'b1;
      arm_mon();
      pin_raw = 1'b0;
      step(400);
      pin_raw = 1'b1;
      step(5);
      arm = 1'b0;
      chk(!saw_off && mode_serial, "R8 serial ack", {saw_off, mode_serial}, 1);
      ack_hold = 1'b0;

      // R7 boundary: exactly the limit stays on, one more shuts down
      arm_mon();
      pin_raw = 1'b0;
      step(P_SHDN);
      pin_raw = 1'b1;
      step(5);
      arm = 1'b0;
      chk(!saw_off && mode_serial, "R7 limit holds", {saw_off, mode_serial}, 1);
      arm_mon();
      pin_raw = 1'b0;
      step(P_SHDN + 1);
      pin_raw = 1'b1;
      step(5);
      arm = 1'b0;
      chk(saw_off, "R7 limit plus one", saw_off, 1);
      chk(!off_ser && !off_lock, "R7 off clears", {off_ser, off_lock}, 0);

      // R10: the rising edge after shutdown starts a fresh window
      chk(enable && !mode_locked, "R10 new window", {enable, mode_locked}, 2);
      step(150);
      chk(mode_locked && !mode_serial, "R10 default pwm", {mode_locked, mode_serial}, 2);

      // R1: reset in the middle of operation
      rst_n = 1'b0;
      step(2);
      chk(!enable && !mode_locked, "R1 mid reset", {enable, mode_locked}, 0);
      pin_raw = 1'b0;
      rst_n = 1'b1;
      step(3);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule